// File: doc/BRIEF.md
# Interruption Context Register Bank

This block holds the three control registers that a processor core uses to save interruption context: a frame-state register (a valid flag plus the saved stack-frame marker), an immediate-capture register and a table-hash address register. Software reaches them through one access port that carries a register number, a write flag and write data. Each access returns a single response one cycle later. The response holds either the read data or exactly one fault flag.

Hardware updates the bank through an interruption-event port. That port carries a cause code, the immediate field of the faulting instruction, a full cause word for intercepts and an already computed hash-table entry address. Two more hardware requests act on the frame-state register. A cover request snapshots the current frame marker into it. A return request hands the saved marker back so that the caller can reload the current frame. The interruption-collection enable bit and the current privilege level gate what the bank accepts.

Top module: `irq_ctx_bank`

## Requirements
- R1: A frame-state read returns the valid flag in bit 63 and the 38-bit marker in bits 37:0. Bits 62:38 always read zero, and software writes drop whatever is written there.
- R2: A frame-state access (register number 0) at privilege 0 while collection is enabled raises only the illegal-operation fault. It leaves the register unchanged.
- R3: Any access at a privilege level other than 0 raises the privileged-operation fault. It changes no register.
- R4: When both rules are violated, only the privileged-operation fault is raised. No response ever carries both faults.
- R5: An interruption event while collection is enabled clears the frame-state valid flag.
- R6: A cover request while collection is disabled copies the current frame marker into the frame-state register and sets the valid flag. While collection is enabled it has no effect.
- R7: The cycle after a return request, the return-valid output is high and the return-frame output carries the marker that was stored when the request was made.
- R8: An event with cause 1 (check) or 2 (break) stores the 21-bit immediate, zero-extended, in the immediate-capture register (number 1). Cause 3 (branch-unit break) stores zero. Cause 0 leaves the register untouched. This does not depend on the collection bit.
- R9: An event with cause 4 (intercept) writes the full 64-bit cause word into the immediate-capture register.
- R10: An event while collection is enabled loads the hash register (number 2) with the supplied address. An event while collection is disabled leaves it unchanged. Bits 1:0 read zero whatever the source.
- R11: Within one cycle, an event outranks a software write to the immediate or hash register, and a cover request outranks a software write to the frame-state register.
- R12: Every access produces a response one cycle later. Faulted accesses, writes and reads of register number 3 return zero data, and number 3 raises no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| collect_en | input | 1 | Interruption-collection enable |
| priv_lvl | input | 2 | Current privilege level, 0 is most privileged |
| sw_req | input | 1 | Software access strobe |
| sw_we | input | 1 | Access is a write |
| sw_addr | input | 2 | Register number |
| sw_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 64 | Read data, zero on faults and writes |
| rsp_priv_flt | output | 1 | Privileged-operation fault |
| rsp_ill_flt | output | 1 | Illegal-operation fault |
| ev_valid | input | 1 | Interruption event strobe |
| ev_cause | input | 3 | Event cause code |
| ev_imm | input | 21 | Instruction immediate field |
| ev_word | input | 64 | Intercept cause word |
| ev_hash | input | 64 | Hash-table entry address |
| cover_req | input | 1 | Cover request |
| cur_frame | input | 38 | Current frame marker |
| rfi_req | input | 1 | Return-from-interruption request |
| rfi_valid | output | 1 | Return frame available |
| rfi_frame | output | 38 | Saved frame marker for reload |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a software write and a hardware update target the same register in the same cycle. In the other, an access breaks both the privilege rule and the collection rule. The stimulus holds the event, cover or second-rule condition on its inputs during the cycle that carries the software access. The next read then shows which source won. Checks after an interruption compare only the valid flag, because the other frame-state fields are undefined there.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
   localparam int unsigned DATA_W = 64;

   typedef enum logic [2:0] {
      CAUSE_NONE      = 3'd0,
      CAUSE_CHECK     = 3'd1,
      CAUSE_BREAK     = 3'd2,
      CAUSE_BREAK_BR  = 3'd3,
      CAUSE_INTERCEPT = 3'd4
   } irq_cause_e;
endpackage

// File: rtl/irq_ctx_access.sv
module irq_ctx_access #(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned PL_W     = 2,
   parameter int unsigned FRM_NUM  = 0,
   parameter int unsigned IMM_NUM  = 1,
   parameter int unsigned HASH_NUM = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_req,
   input  logic              sw_we,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic [PL_W-1:0]   priv_lvl,
   input  logic              collect_en,
   input  logic [DATA_W-1:0] rd_frm,
   input  logic [DATA_W-1:0] rd_imm,
   input  logic [DATA_W-1:0] rd_hash,
   output logic              wr_frm,
   output logic              wr_imm,
   output logic              wr_hash,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_priv_flt,
   output logic              rsp_ill_flt
);
   localparam logic [ADDR_W-1:0] A_FRM  = ADDR_W'(FRM_NUM);
   localparam logic [ADDR_W-1:0] A_IMM  = ADDR_W'(IMM_NUM);
   localparam logic [ADDR_W-1:0] A_HASH = ADDR_W'(HASH_NUM);

   logic              hit_frm, hit_imm, hit_hash;
   logic              pf, ilf, ok;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      hit_frm  = (sw_addr == A_FRM);
      hit_imm  = (sw_addr == A_IMM);
      hit_hash = (sw_addr == A_HASH);
      // privilege rule is checked first, so it wins over the collection rule
      pf  = sw_req && (priv_lvl != '0);
      ilf = sw_req && !pf && hit_frm && collect_en;
      ok  = sw_req && !pf && !ilf;
      wr_frm  = ok && sw_we && hit_frm;
      wr_imm  = ok && sw_we && hit_imm;
      wr_hash = ok && sw_we && hit_hash;
      rd_mux = '0;
      if (ok && !sw_we) begin
         if (hit_frm)       rd_mux = rd_frm;
         else if (hit_imm)  rd_mux = rd_imm;
         else if (hit_hash) rd_mux = rd_hash;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         rsp_priv_flt <= 1'b0;
         rsp_ill_flt  <= 1'b0;
      end else begin
         rsp_valid    <= sw_req;
         rsp_rdata    <= rd_mux;
         rsp_priv_flt <= pf;
         rsp_ill_flt  <= ilf;
      end
   end
endmodule

// File: rtl/irq_ctx_frame.sv
module irq_ctx_frame #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned FRM_W  = 38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_clr,
   input  logic              cover_set,
   input  logic [FRM_W-1:0]  cover_frame,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              frm_valid,
   output logic [FRM_W-1:0]  frm_marker,
   output logic [DATA_W-1:0] frm_word
);
   localparam int unsigned RSV_W = DATA_W - 1 - FRM_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frm_valid  <= 1'b0;
         frm_marker <= '0;
      end else if (ev_clr) begin
         frm_valid  <= 1'b0;
      end else if (cover_set) begin
         frm_valid  <= 1'b1;
         frm_marker <= cover_frame;
      end else if (wr_en) begin
         frm_valid  <= wr_data[DATA_W-1];
         frm_marker <= wr_data[FRM_W-1:0];
      end
   end

   assign frm_word = {frm_valid, {RSV_W{1'b0}}, frm_marker};
endmodule

// File: rtl/irq_ctx_capture.sv
module irq_ctx_capture
   import irq_ctx_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned IMM_W    = 21,
   parameter int unsigned HASH_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  irq_cause_e        ev_cause,
   input  logic              collect_en,
   input  logic [IMM_W-1:0]  ev_imm,
   input  logic [DATA_W-1:0] ev_word,
   input  logic [DATA_W-1:0] ev_hash,
   input  logic              wr_imm,
   input  logic              wr_hash,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] imm_q,
   output logic [DATA_W-1:0] hash_q
);
   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] hash_mask;
   logic              imm_ev;
   logic [DATA_W-1:0] imm_ev_val;

   generate
      if (IMM_W == DATA_W) begin : g_imm_full
         assign imm_ext = ev_imm;
      end else begin : g_imm_zext
         assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, ev_imm};
      end
      if (HASH_LSB > 0) begin : g_hash_ign
         assign hash_mask = {{(DATA_W-HASH_LSB){1'b1}}, {HASH_LSB{1'b0}}};
      end else begin : g_hash_all
         assign hash_mask = '1;
      end
   endgenerate

   always_comb begin
      imm_ev     = 1'b0;
      imm_ev_val = '0;
      if (ev_valid) begin
         case (ev_cause)
            CAUSE_CHECK, CAUSE_BREAK: begin imm_ev = 1'b1; imm_ev_val = imm_ext; end
            CAUSE_BREAK_BR:           begin imm_ev = 1'b1; imm_ev_val = '0;      end
            CAUSE_INTERCEPT:          begin imm_ev = 1'b1; imm_ev_val = ev_word; end
            default:                  begin imm_ev = 1'b0; imm_ev_val = '0;      end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imm_q  <= '0;
         hash_q <= '0;
      end else begin
         if (imm_ev)      imm_q <= imm_ev_val;
         else if (wr_imm) imm_q <= wr_data;
         if (ev_valid && collect_en) hash_q <= ev_hash & hash_mask;
         else if (wr_hash)           hash_q <= wr_data & hash_mask;
      end
   end
endmodule

// File: rtl/irq_ctx_bank.sv
module irq_ctx_bank
   import irq_ctx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned PL_W     = 2,
   parameter int unsigned FRM_W    = 38,
   parameter int unsigned IMM_W    = 21,
   parameter int unsigned HASH_LSB = 2,
   parameter int unsigned FRM_NUM  = 0,
   parameter int unsigned IMM_NUM  = 1,
   parameter int unsigned HASH_NUM = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              collect_en,
   input  logic [PL_W-1:0]   priv_lvl,
   input  logic              sw_req,
   input  logic              sw_we,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic [63:0]       sw_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   output logic              rsp_priv_flt,
   output logic              rsp_ill_flt,
   input  logic              ev_valid,
   input  logic [2:0]        ev_cause,
   input  logic [IMM_W-1:0]  ev_imm,
   input  logic [63:0]       ev_word,
   input  logic [63:0]       ev_hash,
   input  logic              cover_req,
   input  logic [FRM_W-1:0]  cur_frame,
   input  logic              rfi_req,
   output logic              rfi_valid,
   output logic [FRM_W-1:0]  rfi_frame
);
   generate
      if (FRM_W + 2 > DATA_W) begin : g_bad_frm
         $error("frame marker leaves no room for valid and reserved bits");
      end
      if (IMM_W > DATA_W || IMM_W == 0) begin : g_bad_imm
         $error("immediate width out of range");
      end
      if (HASH_LSB >= DATA_W) begin : g_bad_hash
         $error("ignored hash bits exceed word");
      end
      if (FRM_NUM == IMM_NUM || FRM_NUM == HASH_NUM || IMM_NUM == HASH_NUM) begin : g_bad_num
         $error("register numbers must differ");
      end
      if (PL_W == 0 || ADDR_W == 0) begin : g_bad_w
         $error("zero-width select");
      end
   endgenerate

   logic              wr_frm, wr_imm, wr_hash;
   logic              frm_valid;
   logic [FRM_W-1:0]  frm_marker;
   logic [DATA_W-1:0] frm_word, imm_q, hash_q;
   logic              ev_clr, cover_set;

   assign ev_clr    = ev_valid && collect_en;
   assign cover_set = cover_req && !collect_en;

   irq_ctx_access #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PL_W(PL_W),
      .FRM_NUM(FRM_NUM), .IMM_NUM(IMM_NUM), .HASH_NUM(HASH_NUM)
   ) u_access (
      .clk(clk), .rst_n(rst_n),
      .sw_req(sw_req), .sw_we(sw_we), .sw_addr(sw_addr),
      .priv_lvl(priv_lvl), .collect_en(collect_en),
      .rd_frm(frm_word), .rd_imm(imm_q), .rd_hash(hash_q),
      .wr_frm(wr_frm), .wr_imm(wr_imm), .wr_hash(wr_hash),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_priv_flt(rsp_priv_flt), .rsp_ill_flt(rsp_ill_flt)
   );

   irq_ctx_frame #(.DATA_W(DATA_W), .FRM_W(FRM_W)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .ev_clr(ev_clr), .cover_set(cover_set), .cover_frame(cur_frame),
      .wr_en(wr_frm), .wr_data(sw_wdata),
      .frm_valid(frm_valid), .frm_marker(frm_marker), .frm_word(frm_word)
   );

   irq_ctx_capture #(.DATA_W(DATA_W), .IMM_W(IMM_W), .HASH_LSB(HASH_LSB)) u_capture (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_cause(irq_cause_e'(ev_cause)), .collect_en(collect_en),
      .ev_imm(ev_imm), .ev_word(ev_word), .ev_hash(ev_hash),
      .wr_imm(wr_imm), .wr_hash(wr_hash), .wr_data(sw_wdata),
      .imm_q(imm_q), .hash_q(hash_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rfi_valid <= 1'b0;
         rfi_frame <= '0;
      end else begin
         rfi_valid <= rfi_req;
         if (rfi_req) rfi_frame <= frm_marker;
      end
   end
endmodule

// File: rtl/irq_ctx_checker.sv
module irq_ctx_checker #(
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned PL_W    = 2,
   parameter int unsigned FRM_NUM = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              collect_en,
   input logic [PL_W-1:0]   priv_lvl,
   input logic              sw_req,
   input logic [ADDR_W-1:0] sw_addr,
   input logic              rsp_valid,
   input logic [63:0]       rsp_rdata,
   input logic              rsp_priv_flt,
   input logic              rsp_ill_flt,
   input logic              ev_valid,
   input logic              cover_req,
   input logic              rfi_req,
   input logic              rfi_valid,
   input logic              frm_valid
);
   p_ill_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && priv_lvl == '0 && sw_addr == ADDR_W'(FRM_NUM) && collect_en) |=> rsp_ill_flt);

   p_priv_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && priv_lvl != '0) |=> (rsp_priv_flt && !rsp_ill_flt));

   p_one_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_priv_flt, rsp_ill_flt}));

   p_ev_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && collect_en) |=> !frm_valid);

   p_cover_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cover_req && !collect_en) |=> frm_valid);

   p_cover_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cover_req && collect_en && !ev_valid && !sw_req) |=> $stable(frm_valid));

   p_rfi_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rfi_req |=> rfi_valid);

   p_rsp_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req |=> rsp_valid);

   p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_priv_flt || rsp_ill_flt) |-> (rsp_rdata == '0 && rsp_valid));
endmodule

bind irq_ctx_bank irq_ctx_checker #(
   .ADDR_W(ADDR_W), .PL_W(PL_W), .FRM_NUM(FRM_NUM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .collect_en(collect_en), .priv_lvl(priv_lvl),
   .sw_req(sw_req), .sw_addr(sw_addr),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .rsp_priv_flt(rsp_priv_flt), .rsp_ill_flt(rsp_ill_flt),
   .ev_valid(ev_valid), .cover_req(cover_req),
   .rfi_req(rfi_req), .rfi_valid(rfi_valid), .frm_valid(frm_valid)
);

// File: tb/test_irq_ctx_bank.sv
module test_irq_ctx_bank;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        collect_en;
   logic [1:0]  priv_lvl;
   logic        sw_req, sw_we;
   logic [1:0]  sw_addr;
   logic [63:0] sw_wdata;
   logic        rsp_valid, rsp_priv_flt, rsp_ill_flt;
   logic [63:0] rsp_rdata;
   logic        ev_valid;
   logic [2:0]  ev_cause;
   logic [20:0] ev_imm;
   logic [63:0] ev_word, ev_hash;
   logic        cover_req;
   logic [37:0] cur_frame;
   logic        rfi_req, rfi_valid;
   logic [37:0] rfi_frame;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [63:0] data;
      logic [63:0] mask;
      logic        pf;
      logic        ilf;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ctx_bank i_irq_ctx_bank (
      .clk(clk), .rst_n(rst_n), .collect_en(collect_en), .priv_lvl(priv_lvl),
      .sw_req(sw_req), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_priv_flt(rsp_priv_flt), .rsp_ill_flt(rsp_ill_flt),
      .ev_valid(ev_valid), .ev_cause(ev_cause), .ev_imm(ev_imm),
      .ev_word(ev_word), .ev_hash(ev_hash),
      .cover_req(cover_req), .cur_frame(cur_frame),
      .rfi_req(rfi_req), .rfi_valid(rfi_valid), .rfi_frame(rfi_frame)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard entries as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R12 unexpected response", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check((rsp_rdata & e.mask) == (e.data & e.mask), {e.tag, " data"},
                  rsp_rdata & e.mask, e.data & e.mask);
            check(rsp_priv_flt == e.pf && rsp_ill_flt == e.ilf, {e.tag, " faults"},
                  {62'd0, rsp_priv_flt, rsp_ill_flt}, {62'd0, e.pf, e.ilf});
         end
      end
   end

   task automatic idle();
      sw_req = 0; sw_we = 0; ev_valid = 0; cover_req = 0; rfi_req = 0;
   endtask

   // called just after a negedge; extra inputs may be set by the caller first
   task automatic sw(input bit we, input logic [1:0] addr, input logic [63:0] wd,
                     input logic [63:0] ed, input logic [63:0] em,
                     input bit pf, input bit ilf, input string tag);
      exp_t e;
      sw_req = 1; sw_we = we; sw_addr = addr; sw_wdata = wd;
      e.data = ed; e.mask = em; e.pf = pf; e.ilf = ilf; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      idle();
   endtask

   task automatic rd(input logic [1:0] addr, input logic [63:0] ed, input string tag);
      sw(0, addr, 64'd0, ed, '1, 0, 0, tag);
   endtask

   task automatic wr(input logic [1:0] addr, input logic [63:0] wd, input string tag);
      sw(1, addr, wd, 64'd0, '1, 0, 0, tag);
   endtask

   task automatic event_in(input logic [2:0] c, input logic [20:0] im,
                           input logic [63:0] w, input logic [63:0] h);
      ev_valid = 1; ev_cause = c; ev_imm = im; ev_word = w; ev_hash = h;
      @(negedge clk);
      idle();
   endtask

   task automatic cover_in(input logic [37:0] f);
      cover_req = 1; cur_frame = f;
      @(negedge clk);
      idle();
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0; collect_en = 0; priv_lvl = 0; sw_addr = 0; sw_wdata = 0;
      ev_cause = 0; ev_imm = 0; ev_word = 0; ev_hash = 0; cur_frame = 0;
      idle();
      repeat (3) @(negedge clk);
      check(!rsp_valid && !rfi_valid, "R12 reset outputs idle",
            {62'd0, rsp_valid, rfi_valid}, 64'd0);
      rst_n = 1;
      @(negedge clk);

      rd(2'd0, 64'd0, "R1 reset frame");
      // R1 reserved bits dropped on write, read back zero
      wr(2'd0, '1, "R1 write ones");
      rd(2'd0, 64'h8000_003F_FFFF_FFFF, "R1 reserved zero");
      wr(2'd0, 64'h0000_0012_3456_789A, "R1 write marker");
      rd(2'd0, 64'h0000_0012_3456_789A, "R1 marker readback");

      // R2 illegal fault with collection on
      collect_en = 1;
      sw(1, 2'd0, '1, 64'd0, '1, 0, 1, "R2 write illegal");
      sw(0, 2'd0, 64'd0, 64'd0, '1, 0, 1, "R2 read illegal");
      collect_en = 0;
      rd(2'd0, 64'h0000_0012_3456_789A, "R2 frame unchanged");

      // R3 privilege fault on other registers
      wr(2'd1, 64'h1111, "R3 setup imm");
      priv_lvl = 3;
      sw(0, 2'd2, 64'd0, 64'd0, '1, 1, 0, "R3 read hash priv");
      priv_lvl = 1;
      sw(1, 2'd1, 64'h2222, 64'd0, '1, 1, 0, "R3 write imm priv");
      priv_lvl = 0;
      rd(2'd1, 64'h1111, "R3 imm unchanged");

      // R4 both rules violated
      priv_lvl = 2; collect_en = 1;
      sw(1, 2'd0, '1, 64'd0, '1, 1, 0, "R4 priv wins");
      priv_lvl = 0; collect_en = 0;
      rd(2'd0, 64'h0000_0012_3456_789A, "R4 frame unchanged");

      // R6 cover
      cover_in(38'h2A_AAAA_5555);
      rd(2'd0, 64'h8000_002A_AAAA_5555, "R6 cover snapshot");
      collect_en = 1;
      cover_in(38'h11);
      collect_en = 0;
      rd(2'd0, 64'h8000_002A_AAAA_5555, "R6 cover ignored");

      // R7 return request
      rfi_req = 1;
      @(negedge clk);
      idle();
      check(rfi_valid && rfi_frame == 38'h2A_AAAA_5555, "R7 return frame",
            {25'd0, rfi_valid, rfi_frame}, {25'd0, 1'b1, 38'h2A_AAAA_5555});

      // R5 + R10 event with collection on
      collect_en = 1;
      event_in(3'd0, 21'd0, 64'd0, 64'hDEAD_BEEF_0000_1237);
      collect_en = 0;
      sw(0, 2'd0, 64'd0, 64'd0, 64'h8000_0000_0000_0000, 0, 0, "R5 valid cleared");
      rd(2'd2, 64'hDEAD_BEEF_0000_1234, "R10 hash loaded low bits zero");
      rd(2'd1, 64'h1111, "R8 cause 0 leaves imm");

      // R10 event with collection off
      event_in(3'd1, 21'h1F_FFFF, 64'd0, 64'h5555_5555_5555_5555);
      rd(2'd2, 64'hDEAD_BEEF_0000_1234, "R10 hash unchanged");
      rd(2'd1, 64'h0000_0000_001F_FFFF, "R8 check zero-extend");
      event_in(3'd2, 21'h00ABC, 64'd0, 64'd0);
      rd(2'd1, 64'h0000_0000_0000_0ABC, "R8 break immediate");
      event_in(3'd3, 21'h01234, 64'd0, 64'd0);
      rd(2'd1, 64'd0, "R8 branch break zero");
      event_in(3'd4, 21'h00001, 64'hCAFE_F00D_1234_5678, 64'd0);
      rd(2'd1, 64'hCAFE_F00D_1234_5678, "R9 intercept word");
      wr(2'd2, 64'h0000_0000_0000_00FF, "R10 sw hash");
      rd(2'd2, 64'h0000_0000_0000_00FC, "R10 sw hash low bits");

      // R11 same-cycle precedence
      cover_req = 1; cur_frame = 38'h77;
      wr(2'd0, 64'h0000_0000_0000_0055, "R11 write with cover");
      rd(2'd0, 64'h8000_0000_0000_0077, "R11 cover beats write");
      ev_valid = 1; ev_cause = 3'd4; ev_word = 64'h0123_4567_89AB_CDEF; ev_hash = 64'd0;
      wr(2'd1, 64'h99, "R11 write with event");
      rd(2'd1, 64'h0123_4567_89AB_CDEF, "R11 event beats imm write");
      collect_en = 1;
      ev_valid = 1; ev_cause = 3'd0; ev_hash = 64'h0000_0000_ABCD_0008;
      wr(2'd2, 64'hFFFF_0000, "R11 hash write with event");
      collect_en = 0;
      rd(2'd2, 64'h0000_0000_ABCD_0008, "R11 event beats hash write");

      // R12 unmapped register number
      rd(2'd3, 64'd0, "R12 unmapped read");

      @(negedge clk);
      check(sb.size() == 0, "R12 all responses seen", 64'(sb.size()), 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule